// File: doc/BRIEF.md
# Programmed-I/O Byte Buffer with Command Capture

This block sits between a processor register port and a storage-bus data path and carries bytes moved by programmed I/O. Processor writes append bytes at a write pointer and processor reads take them off at a read pointer. The buffer is linear rather than circular. Whenever a read leaves the two pointers equal, both return to slot zero. The top slot is never filled, so the buffer holds at most `DEPTH-1` bytes. Alongside the pointers the block keeps a signed residual transfer count. Each accepted write raises it by one and each consumed read lowers it by one.

A mode input sends processor writes into a separate command buffer with its own length counter, and that buffer is capped at `CMD_DEPTH` bytes. The command consumer reads this buffer through an index port and empties it with a clear strobe. A status-load strobe fills the data buffer with a two-byte response, the status byte followed by a zero byte, and raises the interrupt. A selection-start strobe empties the data buffer and zeroes the residual count. Reads made while the bus phase is data-out return zero and take nothing from the buffer.

Top module: `pio_byte_buffer`

## Requirements
- R1: With `cmd_mode`=1, a write stores `wr_data` at index `cmd_len` of the command buffer and increments `cmd_len`. When `cmd_len` equals `CMD_DEPTH` the write is dropped and `overrun` pulses high for one cycle after it. Command writes leave `fill_count` and `residual` unchanged.
- R2: With `cmd_mode`=0, a write while the write pointer equals `DEPTH-1` is dropped and `overrun` pulses high one cycle later. Any other write stores the byte, advances the write pointer and adds 1 to `residual`. At most `DEPTH-1` bytes can therefore be held.
- R3: A read while `phase`==3'b000 (data-out) sets `rd_data` to 0 on the next cycle and consumes nothing.
- R4: With any other `phase`, a read with bytes present puts the oldest byte on `rd_data` on the next cycle, advances the read pointer and subtracts 1 from `residual`. A read of an empty buffer leaves `rd_data` and `residual` unchanged.
- R5: When a read leaves the read and write pointers equal, both return to zero. After a full drain, `DEPTH-1` further writes are accepted without overrun.
- R6: `status_load` makes the buffer hold `status_byte` followed by 0x00, sets `fill_count` and `residual` to 2, and sets `irq`.
- R7: `sel_start` zeroes `residual` and both pointers. It has priority over `status_load`, and `status_load` has priority over writes and reads.
- R8: `cmd_clr` zeroes `cmd_len` and wins over a command write in the same cycle.
- R9: `fill_count` always equals the write pointer minus the read pointer.
- R10: A cycle with both `wr_en` and `rd_en` performs only the write. The read is ignored.
- R11: `irq` is cleared by `irq_clr`. A `status_load` in the same cycle keeps it set.
- R12: After reset, all counts, pointers, `rd_data`, `irq` and `overrun` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_mode | input | 1 | Route writes to the command buffer |
| wr_en | input | 1 | Processor write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Processor read strobe |
| phase | input | 3 | Bus phase bits; 000 is data-out |
| rd_data | output | 8 | Byte returned by the last read |
| sel_start | input | 1 | New selection: empty buffer and zero residual |
| status_load | input | 1 | Load the two-byte status response |
| status_byte | input | 8 | Status value for the response |
| irq_clr | input | 1 | Clear the interrupt |
| irq | output | 1 | Interrupt request |
| fill_count | output | PTR_W | Bytes held (write minus read pointer) |
| residual | output | RES_W | Signed residual transfer size |
| overrun | output | 1 | One-cycle pulse after a dropped write |
| cmd_clr | input | 1 | Empty the command buffer |
| cmd_len | output | CMD_W | Command bytes captured |
| cmd_idx | input | CMD_IW | Command buffer read index |
| cmd_byte | output | 8 | Command byte at `cmd_idx` |

## Verification
The data path is swept over every write burst length from zero up to one past capacity. Each burst is followed by a complete drain. This separates the accepted count from the dropped count and shows whether the pointers snap back so that the next burst gets full capacity. Command capture is driven two bytes past its cap, and every stored byte is then read back by index. Reads in data-out phase, reads of an empty buffer, simultaneous read and write, and each strobe colliding with another strobe are each tried once. These cases tell the defined priority order apart from alternatives that differ only by one gate.

// File: rtl/pio_buf_pkg.sv
package pio_buf_pkg;

  // Bytes held between the two pointers of a linear buffer.
  function automatic int bytes_held(int wp, int rp);
    return wp - rp;
  endfunction

  // Residual count after one accepted write (+1) or consumed read (-1).
  function automatic int residual_step(int res, bit up);
    return up ? res + 1 : res - 1;
  endfunction

  // Linear pointer advance after a read: snaps to zero when it meets the writer.
  function automatic bit reader_meets_writer(int rp, int wp);
    return (rp + 1) == wp;
  endfunction

endpackage

// File: rtl/pio_data_store.sv
module pio_data_store
  import pio_buf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int RES_W = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    do_sel,
  input  logic                    do_stat,
  input  logic [7:0]              stat_byte,
  input  logic                    do_wr,
  input  logic [7:0]              wr_data,
  input  logic                    do_rd,
  input  logic                    data_out,
  output logic [7:0]              rd_data,
  output logic [PTR_W-1:0]        fill,
  output logic signed [RES_W-1:0] residual,
  output logic                    drop
);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             full;
  logic             accept_wr;
  logic             take_rd;
  logic             snap;

  assign full      = (wptr == PTR_W'(DEPTH - 1));
  assign accept_wr = do_wr && !full;
  assign drop      = do_wr && full;
  assign take_rd   = do_rd && !data_out && (rptr < wptr);
  assign snap      = reader_meets_writer(int'(rptr), int'(wptr));
  assign fill      = PTR_W'(bytes_held(int'(wptr), int'(rptr)));

  always_ff @(posedge clk) begin
    if (do_stat) begin
      mem[0] <= stat_byte;
      mem[1] <= 8'h00;
    end else if (accept_wr) begin
      mem[wptr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      residual <= '0;
      rd_data  <= '0;
    end else if (do_sel) begin
      wptr     <= '0;
      rptr     <= '0;
      residual <= '0;
    end else if (do_stat) begin
      wptr     <= PTR_W'(2);
      rptr     <= '0;
      residual <= RES_W'(2);
    end else if (accept_wr) begin
      wptr     <= wptr + 1'b1;
      residual <= RES_W'(residual_step(int'(residual), 1'b1));
    end else if (do_rd && data_out) begin
      rd_data  <= 8'h00;
    end else if (take_rd) begin
      rd_data  <= mem[rptr];
      residual <= RES_W'(residual_step(int'(residual), 1'b0));
      if (snap) begin
        rptr <= '0;
        wptr <= '0;
      end else begin
        rptr <= rptr + 1'b1;
      end
    end
  end

  AST_WPTR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    wptr <= PTR_W'(DEPTH - 1)) else $error("write pointer past cap"); // R2

  AST_PTR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    rptr <= wptr) else $error("read pointer ahead of writer"); // R5

  AST_DOUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rd && data_out && !do_sel && !do_stat && !do_wr) |=> (rd_data == 8'h00 && $stable(rptr))) else $error("data-out read consumed"); // R3

  AST_DRAIN_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    (take_rd && !do_sel && !do_stat && !do_wr && snap) |=> (wptr == '0 && rptr == '0)) else $error("no snap on drain"); // R5

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !do_sel && !do_stat) |=> $stable(wptr)) else $error("write past cap"); // R2

endmodule

// File: rtl/pio_cmd_store.sv
module pio_cmd_store #(
  parameter int CMD_DEPTH = 32,
  localparam int CMD_W  = $clog2(CMD_DEPTH + 1),
  localparam int CMD_IW = $clog2(CMD_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              do_wr,
  input  logic [7:0]        wr_data,
  input  logic [CMD_IW-1:0] idx,
  output logic [7:0]        byte_out,
  output logic [CMD_W-1:0]  len,
  output logic              drop
);

  logic [7:0] mem [CMD_DEPTH];
  logic       capped;
  logic       store;

  assign capped   = (len == CMD_W'(CMD_DEPTH));
  assign store    = do_wr && !capped && !clr;
  assign drop     = do_wr && capped && !clr;
  assign byte_out = mem[idx];

  always_ff @(posedge clk) begin
    if (store) mem[len[CMD_IW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     len <= '0;
    else if (clr)   len <= '0;
    else if (store) len <= len + 1'b1;
  end

  AST_CMD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    len <= CMD_W'(CMD_DEPTH)) else $error("command length past cap"); // R1

  AST_CMD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (len == '0)) else $error("command clear ignored"); // R8

endmodule

// File: rtl/pio_byte_buffer.sv
module pio_byte_buffer #(
  parameter int DEPTH     = 16,
  parameter int CMD_DEPTH = 32,
  parameter int RES_W     = 16,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int CMD_W  = $clog2(CMD_DEPTH + 1),
  localparam int CMD_IW = $clog2(CMD_DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_mode,
  input  logic                    wr_en,
  input  logic [7:0]              wr_data,
  input  logic                    rd_en,
  input  logic [2:0]              phase,
  output logic [7:0]              rd_data,
  input  logic                    sel_start,
  input  logic                    status_load,
  input  logic [7:0]              status_byte,
  input  logic                    irq_clr,
  output logic                    irq,
  output logic [PTR_W-1:0]        fill_count,
  output logic signed [RES_W-1:0] residual,
  output logic                    overrun,
  input  logic                    cmd_clr,
  output logic [CMD_W-1:0]        cmd_len,
  input  logic [CMD_IW-1:0]       cmd_idx,
  output logic [7:0]              cmd_byte
);

  logic do_sel, do_stat, do_dwr, do_cwr, do_rd;
  logic drop_data, drop_cmd;

  // Priority: selection > status load > write > read.
  assign do_sel  = sel_start;
  assign do_stat = status_load && !sel_start;
  assign do_dwr  = wr_en && !cmd_mode && !do_sel && !do_stat;
  assign do_cwr  = wr_en && cmd_mode && !do_sel && !do_stat;
  assign do_rd   = rd_en && !wr_en && !do_sel && !do_stat;

  pio_data_store #(.DEPTH(DEPTH), .RES_W(RES_W)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .do_sel   (do_sel),
    .do_stat  (do_stat),
    .stat_byte(status_byte),
    .do_wr    (do_dwr),
    .wr_data  (wr_data),
    .do_rd    (do_rd),
    .data_out (phase == 3'b000),
    .rd_data  (rd_data),
    .fill     (fill_count),
    .residual (residual),
    .drop     (drop_data)
  );

  pio_cmd_store #(.CMD_DEPTH(CMD_DEPTH)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cmd_clr),
    .do_wr   (do_cwr),
    .wr_data (wr_data),
    .idx     (cmd_idx),
    .byte_out(cmd_byte),
    .len     (cmd_len),
    .drop    (drop_cmd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun <= 1'b0;
      irq     <= 1'b0;
    end else begin
      overrun <= drop_data || drop_cmd;
      if (do_stat)      irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  AST_STATUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    do_stat |=> (irq && fill_count == PTR_W'(2) && residual == RES_W'(2))) else $error("status load"); // R6

  AST_SEL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sel_start |=> (fill_count == '0 && residual == '0)) else $error("selection clear"); // R7

  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(wr_en)) else $error("overrun without write"); // R2

  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !status_load) |=> !irq) else $error("irq not cleared"); // R11

endmodule

// File: tb/test_pio_byte_buffer.sv
module test_pio_byte_buffer;
  localparam int DEPTH = 16;
  localparam int CMDD  = 32;

  logic clk = 0, rst_n = 0;
  logic cmd_mode = 0, wr_en = 0, rd_en = 0, sel_start = 0, status_load = 0;
  logic irq_clr = 0, cmd_clr = 0;
  logic [7:0] wr_data = 0, status_byte = 0;
  logic [2:0] phase = 3'b001;
  logic [4:0] cmd_idx = 0;
  logic [7:0] rd_data, cmd_byte;
  logic irq, overrun;
  logic [3:0] fill_count;
  logic signed [15:0] residual;
  logic [5:0] cmd_len;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pio_byte_buffer i_pio_byte_buffer (
    .clk(clk), .rst_n(rst_n), .cmd_mode(cmd_mode), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .phase(phase), .rd_data(rd_data), .sel_start(sel_start),
    .status_load(status_load), .status_byte(status_byte), .irq_clr(irq_clr), .irq(irq),
    .fill_count(fill_count), .residual(residual), .overrun(overrun), .cmd_clr(cmd_clr),
    .cmd_len(cmd_len), .cmd_idx(cmd_idx), .cmd_byte(cmd_byte));

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_data = d; wr_en = 1; @(negedge clk); wr_en = 0;
  endtask

  task automatic rd();
    rd_en = 1; @(negedge clk); rd_en = 0;
  endtask

  task automatic pulse_sel();
    sel_start = 1; @(negedge clk); sel_start = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int acc;
    int ovr_seen;
    logic [7:0] last;
    @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
    check("R12 fill", fill_count, 0);
    check("R12 residual", residual, 0);
    check("R12 irq", irq, 0);
    check("R12 rd_data", rd_data, 0);
    check("R12 cmd_len", cmd_len, 0);
    check("R12 overrun", overrun, 0);

    // R2 R4 R5 R9: sweep burst lengths past capacity, then drain
    for (int n = 0; n <= DEPTH; n++) begin
      pulse_sel();
      ovr_seen = 0;
      for (int i = 0; i < n; i++) begin
        wr(8'((n * 16 + i * 7) & 255));
        if (overrun) ovr_seen++;
      end
      acc = (n < DEPTH) ? n : DEPTH - 1;
      check("R2 accepted count", fill_count, acc);
      check("R2 residual", residual, acc);
      check("R2 overrun drops", ovr_seen, n - acc);
      for (int i = 0; i < acc; i++) begin
        rd();
        check("R4 read byte", rd_data, (n * 16 + i * 7) & 255);
        check("R9 fill after read", fill_count, acc - i - 1);
      end
      check("R4 residual drained", residual, 0);
      last = rd_data;
      rd();
      check("R4 empty read keeps data", rd_data, last);
      check("R4 empty read keeps residual", residual, 0);
      // R5: full capacity available again after the drain
      if (n == DEPTH) begin
        ovr_seen = 0;
        for (int i = 0; i < DEPTH - 1; i++) begin wr(8'(i)); if (overrun) ovr_seen++; end
        check("R5 capacity after snap", fill_count, DEPTH - 1);
        check("R5 no overrun after snap", ovr_seen, 0);
      end
    end

    // R3: data-out phase read
    pulse_sel();
    wr(8'h11); wr(8'h22); wr(8'h33);
    rd(); // rd_data = 0x11
    phase = 3'b000; rd();
    check("R3 data-out returns zero", rd_data, 0);
    check("R3 data-out consumes nothing", fill_count, 2);
    phase = 3'b010; rd();
    check("R3 next byte intact", rd_data, 8'h22);

    // R10: simultaneous read and write
    wr_data = 8'h44; wr_en = 1; rd_en = 1; @(negedge clk); wr_en = 0; rd_en = 0;
    check("R10 write done", fill_count, 2);
    check("R10 read ignored", rd_data, 8'h22);
    check("R10 residual", residual, 2);

    // R1 R8: command capture
    cmd_clr = 1; @(negedge clk); cmd_clr = 0;
    check("R8 cmd clear", cmd_len, 0);
    cmd_mode = 1; ovr_seen = 0;
    for (int i = 0; i < CMDD + 2; i++) begin wr(8'(i ^ 8'hA5)); if (overrun) ovr_seen++; end
    check("R1 cmd length capped", cmd_len, CMDD);
    check("R1 cmd overrun", ovr_seen, 2);
    check("R1 data fill untouched", fill_count, 2);
    check("R1 residual untouched", residual, 2);
    for (int i = 0; i < CMDD; i++) begin
      cmd_idx = 5'(i); #1;
      check("R1 cmd byte", cmd_byte, (i ^ 8'hA5) & 255);
    end
    wr_data = 8'h5A; wr_en = 1; cmd_clr = 1; @(negedge clk); wr_en = 0; cmd_clr = 0;
    check("R8 clear wins", cmd_len, 0);
    cmd_mode = 0;

    // R6 R11: status response
    pulse_sel();
    for (int i = 0; i < 5; i++) wr(8'(i));
    status_byte = 8'h3C; status_load = 1; @(negedge clk); status_load = 0;
    check("R6 fill", fill_count, 2);
    check("R6 residual", residual, 2);
    check("R6 irq", irq, 1);
    rd(); check("R6 status byte", rd_data, 8'h3C);
    rd(); check("R6 zero byte", rd_data, 0);
    check("R6 drained", fill_count, 0);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    check("R11 irq cleared", irq, 0);
    irq_clr = 1; status_load = 1; @(negedge clk); irq_clr = 0; status_load = 0;
    check("R11 set wins", irq, 1);

    // R7: selection clears, priority over status load and write
    pulse_sel();
    wr(8'h01); wr(8'h02); wr(8'h03); wr(8'h04); rd();
    sel_start = 1; status_load = 1; wr_data = 8'h09; wr_en = 1;
    @(negedge clk); sel_start = 0; status_load = 0; wr_en = 0;
    check("R7 fill cleared", fill_count, 0);
    check("R7 residual cleared", residual, 0);
    // status load beats write
    wr(8'h07);
    status_byte = 8'h81; status_load = 1; wr_data = 8'h66; wr_en = 1;
    @(negedge clk); status_load = 0; wr_en = 0;
    check("R7 status over write", fill_count, 2);
    rd(); check("R7 status byte first", rd_data, 8'h81);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule